// File: doc/BRIEF.md
# Auto-Reload Wakeup Timer

This block is a periodic wakeup down-counter that runs from a low-speed base clock. Its tick comes either from a free-running divider of the base clock (by 16, 8, 4 or 2) or from an external once-per-second strobe. The counter reloads from a programmable value. Each time the count expires, it raises a sticky wakeup flag. An interrupt request is the flag gated by an interrupt-enable bit.

Software may change the reload value only while the timer is stopped. A write-allowed status bit tells it when that is the case. The bit follows the enable input with a two-cycle handshake. Two of the select codes stretch the counter to 17 bits by adding 2^16 to the reload value, which gives wakeup periods longer than 18 hours on the 1 Hz strobe.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, `wake_flag` is 0, `irq` is 0, `wr_ok` is 1 and the stored reload value is 0.
- R2: With `clk_sel` equal to 0, 1, 2 or 3, one tick occurs every 16, 8, 4 or 2 base-clock cycles respectively, so the flag sets every (reload+1) times that many cycles.
- R3: With `clk_sel` equal to 4 or 5, each base-clock cycle in which `sec_tick` is 1 is one tick. The first flag comes on the (reload+1)th tick that counts after the timer starts, and a tick counts from the second cycle after `wk_en` rises.
- R4: With `clk_sel` equal to 6 or 7, ticks come from `sec_tick`, and `clk_sel` bit 1 acts as bit 16 of the reload value. With a reload of 0 the flag therefore sets on tick 65537.
- R5: While the timer is enabled, the flag sets again every (reload+1) ticks after each expiry.
- R6: `wr_ok` falls 2 base-clock cycles after `wk_en` is set, and rises 2 cycles after `wk_en` is cleared.
- R7: `reload_wr` stores `reload_in` only when `wk_en` is 0 and `wr_ok` is 1. At any other time it is ignored, including the cycle in which `wk_en` is cleared.
- R8: The flag is sticky. Only a `flag_clr` pulse (a software write of 0) clears it. If an expiry and `flag_clr` fall in the same cycle, the flag stays set.
- R9: `irq` is `wake_flag` AND `irq_en`.
- R10: While disabled, the counter reloads and holds, so the next enable restarts a full (reload+1)-tick period.
- R11: The combination of a reload value of 0 and `clk_sel` 3 is forbidden while the timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | Once-per-second strobe, one cycle wide |
| wk_en | input | 1 | Timer enable |
| clk_sel | input | 3 | Tick source and 17-bit mode select |
| reload_wr | input | 1 | Reload value write strobe |
| reload_in | input | 16 | Reload value to store |
| flag_clr | input | 1 | Flag clear strobe (software writes 0) |
| irq_en | input | 1 | Interrupt enable |
| wake_flag | output | 1 | Sticky wakeup flag |
| wr_ok | output | 1 | Reload value may be written |
| irq | output | 1 | Interrupt request |

## Verification
An expiry of the counter and a software clear of the flag can land in the same base-clock cycle. The bench provokes this by running the 1 Hz path with a reload of 0, so that every strobe cycle is an expiry. It then raises `flag_clr` in the same cycle as a strobe, and the flag must read 1 on the next sample. A clear with no strobe must then read 0. The same kind of collision is forced for a reload write that arrives in the very cycle the enable drops: that write is judged ignored, because the following run still takes the old number of ticks to expire.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
   localparam int unsigned RELOAD_W = 16;
   localparam int unsigned SEL_W    = 3;
   localparam int unsigned DIV_STG  = 4;

   typedef enum logic [SEL_W-1:0] {
      SEL_DIV16 = 3'd0,
      SEL_DIV8  = 3'd1,
      SEL_DIV4  = 3'd2,
      SEL_DIV2  = 3'd3,
      SEL_SEC   = 3'd4,
      SEL_SEC_B = 3'd5,
      SEL_SEC17 = 3'd6,
      SEL_SEC_C = 3'd7
   } wkt_sel_e;
endpackage

// File: rtl/wkt_tick_gen.sv
module wkt_tick_gen #(
   parameter int unsigned STAGES = 4,
   parameter int unsigned SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_tick,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned DIV_IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;

   initial begin
      if (STAGES < 1 || STAGES > 8) $error("wkt_tick_gen: STAGES out of range");
      if (SEL_W < DIV_IDX_W + 1) $error("wkt_tick_gen: SEL_W too narrow");
   end

   logic [STAGES-1:0] presc;
   logic [STAGES-1:0] div_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) presc <= '0;
      else        presc <= presc + 1'b1;
   end

   // select i divides by 2^(STAGES-i)
   for (genvar i = 0; i < STAGES; i++) begin : g_div
      assign div_tick[i] = &presc[STAGES-1-i:0];
   end

   logic [DIV_IDX_W-1:0] div_idx;
   assign div_idx = sel[DIV_IDX_W-1:0];

   always_comb begin
      if (sel[SEL_W-1]) tick = sec_tick;
      else if (int'(div_idx) < STAGES) tick = div_tick[div_idx];
      else tick = 1'b0;
   end
endmodule

// File: rtl/wkt_handshake.sv
module wkt_handshake (
   input  logic clk,
   input  logic rst_n,
   input  logic wk_en,
   output logic run,
   output logic wr_ok
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         wr_ok <= 1'b1;
      end else begin
         en_q  <= wk_en;
         wr_ok <= ~en_q;
      end
   end

   assign run = en_q;

   // R6: two cycles of steady enable leave writes closed
   a_r6_wrok_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (wk_en && $past(wk_en)) |=> !wr_ok);
   // R6: two cycles of steady disable leave writes open
   a_r6_wrok_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (!wk_en && $past(!wk_en)) |=> wr_ok);
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
   parameter int unsigned CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload_full,
   input  logic             flag_clr,
   output logic             flag
);
   initial begin
      if (CNT_W < 2) $error("wkt_counter: CNT_W too small");
   end

   logic [CNT_W-1:0] cnt;
   logic             expire;

   assign expire = run && tick && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= reload_full;
      end else if (tick) begin
         cnt <= (cnt == '0) ? reload_full : cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (expire)   flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   // R10: a stopped counter sits at the reload value
   a_r10_hold_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $stable(reload_full)) |=> (cnt == $past(reload_full)));
   // R8: the flag only drops after a clear request
   a_r8_fall_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(flag_clr));
   // R5: the flag only rises on a tick while running
   a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(run && tick));
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
   import wkt_pkg::*;
#(
   parameter int unsigned RLD_W  = RELOAD_W,
   parameter int unsigned STAGES = DIV_STG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_tick,
   input  logic             wk_en,
   input  logic [SEL_W-1:0] clk_sel,
   input  logic             reload_wr,
   input  logic [RLD_W-1:0] reload_in,
   input  logic             flag_clr,
   input  logic             irq_en,
   output logic             wake_flag,
   output logic             wr_ok,
   output logic             irq
);
   localparam int unsigned CNT_W = RLD_W + 1;

   initial begin
      if (RLD_W < 2) $error("wakeup_timer: RLD_W too small");
      if (SEL_W != 3) $error("wakeup_timer: select width must be 3");
   end

   logic             run;
   logic             tick;
   logic [RLD_W-1:0] reload_q;
   logic [CNT_W-1:0] reload_full;
   logic             wr_accept;

   wkt_handshake u_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .wk_en (wk_en),
      .run   (run),
      .wr_ok (wr_ok)
   );

   wkt_tick_gen #(.STAGES(STAGES), .SEL_W(SEL_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .sel      (clk_sel),
      .tick     (tick)
   );

   assign wr_accept = reload_wr && !wk_en && wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reload_q <= '0;
      else if (wr_accept) reload_q <= reload_in;
   end

   // top select bit opens 17-bit mode, bit 1 becomes reload bit RLD_W
   assign reload_full = {clk_sel[SEL_W-1] & clk_sel[1], reload_q};

   wkt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .tick        (tick),
      .reload_full (reload_full),
      .flag_clr    (flag_clr),
      .flag        (wake_flag)
   );

   assign irq = wake_flag & irq_en;

   // R7: a write outside the open window leaves the value alone
   a_r7_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_wr && (wk_en || !wr_ok)) |=> $stable(reload_q));
   // R11: forbidden pairing of fastest tick and zero reload
   a_r11_forbidden_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (run && clk_sel == SEL_DIV2) |-> (reload_q != '0));
   // R9: request never stands without the flag
   a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (wake_flag && irq_en));
endmodule

// File: tb/wakeup_timer_bench.sv
module wakeup_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        wk_en = 1'b0;
   logic [2:0]  clk_sel = 3'd4;
   logic        reload_wr = 1'b0;
   logic [15:0] reload_in = '0;
   logic        flag_clr = 1'b0;
   logic        irq_en = 1'b0;
   logic        wake_flag, wr_ok, irq;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;
   int exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wakeup_timer u_wakeup_timer (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wk_en(wk_en),
      .clk_sel(clk_sel), .reload_wr(reload_wr), .reload_in(reload_in),
      .flag_clr(flag_clr), .irq_en(irq_en),
      .wake_flag(wake_flag), .wr_ok(wr_ok), .irq(irq)
   );

   // driver side: queue the expected value
   task automatic expect_val(int e);
      exp_q.push_back(e);
   endtask

   // monitor side: pop and compare against what the design shows
   task automatic observe(string req, int act);
      int e;
      e = exp_q.pop_front();
      n_vec++;
      if (act != e) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, e);
      end
   endtask

   task automatic check(string req, int act, int e);
      expect_val(e);
      observe(req, act);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sec(int n);
      repeat (n) begin
         @(negedge clk) sec_tick = 1'b1;
         @(negedge clk) sec_tick = 1'b0;
      end
   endtask

   task automatic clear_flag();
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
   endtask

   task automatic load(int v);
      @(negedge clk) begin reload_wr = 1'b1; reload_in = 16'(v); end
      @(negedge clk) reload_wr = 1'b0;
   endtask

   task automatic start();
      @(negedge clk) wk_en = 1'b1;
      step(2);
   endtask

   task automatic stop();
      @(negedge clk) wk_en = 1'b0;
      step(3);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   // cycles between two flag rises for a divided select
   task automatic period_check(int sel, int rld, int div);
      int t0, t1, guard;
      stop();
      @(negedge clk) clk_sel = 3'(sel);
      load(rld);
      step(2);
      start();
      expect_val((rld + 1) * div);
      guard = 0;
      while (!wake_flag && guard < 2000) begin step(1); guard++; end
      t0 = cyc;
      clear_flag();
      guard = 0;
      while (!wake_flag && guard < 2000) begin step(1); guard++; end
      t1 = cyc;
      observe("R2", t1 - t0);
      clear_flag();
   endtask

   initial begin
      step(1);
      if (!done) begin
         repeat (WATCHDOG) @(posedge clk);
         n_bad++;
         $display("FAIL watchdog act=timeout exp=finish");
         finish_run();
      end
   end

   initial begin
      step(3);
      check("R1 flag", wake_flag, 0);
      check("R1 wr_ok", wr_ok, 1);
      check("R1 irq", irq, 0);
      @(negedge clk) rst_n = 1'b1;
      step(2);

      // 1 Hz path, reload 2
      clk_sel = 3'd4;
      load(2);
      step(2);
      @(negedge clk) wk_en = 1'b1;
      step(1);
      check("R6 still open", wr_ok, 1);
      step(1);
      check("R6 closed", wr_ok, 0);
      pulse_sec(2);
      check("R3 before expiry", wake_flag, 0);
      pulse_sec(1);
      check("R3 first expiry", wake_flag, 1);
      check("R9 masked", irq, 0);
      @(negedge clk) irq_en = 1'b1;
      #1 check("R9 enabled", irq, 1);
      clear_flag();
      check("R8 cleared", wake_flag, 0);
      check("R9 follows", irq, 0);
      pulse_sec(2);
      check("R5 mid period", wake_flag, 0);
      pulse_sec(1);
      check("R5 second expiry", wake_flag, 1);
      step(5);
      check("R8 sticky", wake_flag, 1);
      clear_flag();

      // R10: partial count then disable and restart
      pulse_sec(1);
      @(negedge clk) wk_en = 1'b0;
      step(1);
      check("R6 not yet open", wr_ok, 0);
      step(1);
      check("R6 open", wr_ok, 1);
      step(1);
      start();
      pulse_sec(2);
      check("R10 full period restart", wake_flag, 0);
      pulse_sec(1);
      check("R10 expiry", wake_flag, 1);
      clear_flag();

      // R7: write while enabled, then write in the disabling cycle
      load(0);
      @(negedge clk) begin wk_en = 1'b0; reload_wr = 1'b1; reload_in = 16'd0; end
      @(negedge clk) reload_wr = 1'b0;
      step(3);
      start();
      pulse_sec(1);
      check("R7 writes ignored", wake_flag, 0);
      pulse_sec(1);
      check("R7 writes ignored", wake_flag, 0);
      pulse_sec(1);
      check("R7 old reload kept", wake_flag, 1);
      clear_flag();

      // R8: expiry and clear in the same cycle, reload 0
      stop();
      load(0);
      step(1);
      start();
      pulse_sec(1);
      check("R3 reload 0 one tick", wake_flag, 1);
      @(negedge clk) begin sec_tick = 1'b1; flag_clr = 1'b1; end
      @(negedge clk) begin sec_tick = 1'b0; flag_clr = 1'b0; end
      check("R8 set wins", wake_flag, 1);
      clear_flag();
      check("R8 plain clear", wake_flag, 0);

      // R4: 17-bit mode, reload 0 -> 65537 ticks
      stop();
      @(negedge clk) clk_sel = 3'd6;
      step(2);
      start();
      @(negedge clk) sec_tick = 1'b1;
      step(65535);
      check("R4 no expiry at 65536", wake_flag, 0);
      step(1);
      @(negedge clk) sec_tick = 1'b0;
      check("R4 expiry at 65537", wake_flag, 1);
      clear_flag();

      // R2: divided base clock
      period_check(0, 3, 16);
      period_check(1, 3, 8);
      period_check(2, 3, 4);
      period_check(3, 3, 2);
      stop();
      finish_run();
   end
endmodule